// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one channel of a DMA engine. Once started with the address of a first descriptor, it reads a chain of descriptors from memory and carries out the copy that each one describes. A descriptor is four 32-bit words: a link to the next descriptor, a source address, a target address and a command word. The command word sets the element width, the burst size, address stepping, byte swapping, peripheral pacing and the event enables. After each descriptor the channel follows the link word. It halts when the link word carries its stop flag, or when the memory returns an error.

Memory traffic goes over a simple single-outstanding request/acknowledge master. Each element is moved as one read from the source followed by one write to the target, with the data carried on the low byte lanes. A peripheral can pace the copy: with pacing enabled, the channel holds each burst until the source or target request input is high. One-cycle event pulses mark the start and the end of a descriptor. Level outputs report that the channel is stopped and that a bus error occurred.

Top module: `dma_chain_engine`

## Requirements
- R1: After reset `stopped` is 1, `busErr` is 0, `memReq` is 0 and no event pulses occur. While `stopped` is 1, no memory request is issued.
- R2: A start pulse while stopped fetches four words at consecutive addresses from the start address with bits 3:0 cleared, in this order: link, source, target, command. The descriptor's transfer then runs. Each next descriptor is fetched from link bits 31:4 (bits 3:0 zero) until a link word with bit 0 set has been completed, after which the channel stops.
- R3: Command bit 31 steps the source address, and bit 30 steps the target address, by the element width after every element. When the bit is clear, every element uses the same address.
- R4: Command bits 15:14 select the element width: 1 = 1 byte, 2 = 2 bytes, 3 = 4 bytes, and 0 is treated as 4 bytes. `memSize` reports this as 0/1/2 for 1/2/4 bytes, and the data sits on the low lanes. Command bits 12:0 give the byte count. A count of zero moves no data but still completes the descriptor.
- R5: Command bit 18 reverses the byte order within each element between the read and the write.
- R6: Command bit 29 makes each burst wait for `srcReq` high, and bit 28 makes it wait for `tgtReq` high. With both bits clear, bursts start without waiting.
- R7: Command bits 17:16 give the burst size: 1 = 8 bytes, 2 = 16 bytes, 3 = 32 bytes, and 0 is treated as 8. The final burst of a descriptor is cut to the bytes that remain.
- R8: When command bit 22 is set, `evStart` pulses for one cycle after the descriptor has been fetched. When bit 21 is set, `evEnd` pulses for one cycle after the descriptor's last write has been acknowledged. The two pulses never coincide.
- R9: An acknowledge with `memErr` high ends the chain with no further request, sets `busErr` and `stopped`, and produces no end event. `busErr` clears on the next start.
- R10: A start pulse while the channel is running has no effect.
- R11: `memReq` stays high, with its address, direction and size unchanged, until `memAck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| startReq | input | 1 | Start pulse |
| firstDesc | input | 32 | Address of the first descriptor |
| srcReq | input | 1 | Source peripheral ready for a burst |
| tgtReq | input | 1 | Target peripheral ready for a burst |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 32 | Byte address |
| memSize | output | 2 | Access size: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| memWdata | output | 32 | Write data, low lanes |
| memRdata | input | 32 | Read data, valid with memAck |
| memAck | input | 1 | Access complete |
| memErr | input | 1 | Error response, valid with memAck |
| evStart | output | 1 | Descriptor start event |
| evEnd | output | 1 | Descriptor end event |
| busErr | output | 1 | Bus error seen since the last start |
| stopped | output | 1 | Channel idle |

## Verification
The assertions assume that `memAck` is raised only while `memReq` is high, for exactly one cycle per access, and that `memErr` is meaningful only alongside `memAck`. The bench's memory model raises an acknowledge one cycle after it sees a request and never acknowledges twice in a row, so it stays inside that contract. Every byte count the bench programs is a multiple of the element width, and source and target regions never overlap, so the expected data can be computed before the transfer starts. Pacing inputs are driven only at negative clock edges.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  localparam int WORD_W = 32;
  localparam int LEN_W  = 13;
  localparam int ALIGN_BITS = 4;

  // command word field positions
  localparam int C_INC_SRC  = 31;
  localparam int C_INC_TGT  = 30;
  localparam int C_PACE_SRC = 29;
  localparam int C_PACE_TGT = 28;
  localparam int C_IRQ_BEG  = 22;
  localparam int C_IRQ_FIN  = 21;
  localparam int C_SWAP     = 18;
  localparam int C_BURST_LO = 16;
  localparam int C_WIDTH_LO = 14;

  typedef enum logic [1:0] {ADDR_DESC, ADDR_SRC, ADDR_TGT} addrSel_e;

  typedef struct packed {
    logic     loadFirst;
    logic     loadNext;
    logic     fetchWord;
    logic     beginBurst;
    logic     capture;
    logic     stepElem;
    addrSel_e addrSel;
  } dpCtrl_t;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_LOADED, S_ARM, S_RD, S_WR, S_STEP, S_DONE
  } chanState_e;
endpackage

// File: rtl/dma_chain_datapath.sv
module dma_chain_datapath
  import dma_chain_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic [WORD_W-1:0] firstDesc,
  input  logic [WORD_W-1:0] memRdata,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic [1:0]        memSize,
  output logic              lastWord,
  output logic              nextStop,
  output logic              lenZero,
  output logic              burstDone,
  output logic              paceSrc,
  output logic              paceTgt,
  output logic              irqBeg,
  output logic              irqFin
);
  localparam int LANES = WORD_W / 8;

  logic [WORD_W-1:0] descBase, linkWord, srcAddr, tgtAddr, cmdWord, dataBuf;
  logic [1:0]        wordIdx;
  logic [LEN_W-1:0]  remain, burstLeft;
  logic [LEN_W-1:0]  elemBytes, burstBytes, stepRemain, stepBurst, firstBurst;
  logic [1:0]        widthCode, burstCode;
  logic [WORD_W-1:0] revWord, swapped;

  assign widthCode = cmdWord[C_WIDTH_LO +: 2];
  assign burstCode = cmdWord[C_BURST_LO +: 2];

  always_comb begin
    unique case (widthCode)
      2'd1:    begin elemBytes = LEN_W'(1); memSize = 2'd0; end
      2'd2:    begin elemBytes = LEN_W'(2); memSize = 2'd1; end
      default: begin elemBytes = LEN_W'(4); memSize = 2'd2; end
    endcase
    unique case (burstCode)
      2'd2:    burstBytes = LEN_W'(16);
      2'd3:    burstBytes = LEN_W'(32);
      default: burstBytes = LEN_W'(8);
    endcase
  end

  assign stepRemain = (remain < elemBytes) ? remain : elemBytes;
  assign stepBurst  = (burstLeft < elemBytes) ? burstLeft : elemBytes;
  assign firstBurst = (remain < burstBytes) ? remain : burstBytes;

  // byte reversal across the full word
  for (genvar b = 0; b < LANES; b++) begin : g_rev
    assign revWord[8*b +: 8] = memRdata[8*(LANES-1-b) +: 8];
  end

  always_comb begin
    swapped = '0;
    unique case (widthCode)
      2'd1: swapped[7:0] = memRdata[7:0];
      2'd2: swapped[15:0] = cmdWord[C_SWAP] ? {memRdata[7:0], memRdata[15:8]}
                                            : memRdata[15:0];
      default: swapped = cmdWord[C_SWAP] ? revWord : memRdata;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      descBase  <= '0;
      linkWord  <= '0;
      srcAddr   <= '0;
      tgtAddr   <= '0;
      cmdWord   <= '0;
      dataBuf   <= '0;
      wordIdx   <= '0;
      remain    <= '0;
      burstLeft <= '0;
    end else begin
      if (ctrl.loadFirst) begin
        descBase <= {firstDesc[WORD_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
        wordIdx  <= '0;
      end else if (ctrl.loadNext) begin
        descBase <= {linkWord[WORD_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
        wordIdx  <= '0;
      end
      if (ctrl.fetchWord) begin
        unique case (wordIdx)
          2'd0: linkWord <= memRdata;
          2'd1: srcAddr  <= memRdata;
          2'd2: tgtAddr  <= memRdata;
          default: begin
            cmdWord <= memRdata;
            remain  <= memRdata[LEN_W-1:0];
          end
        endcase
        wordIdx <= wordIdx + 2'd1;
      end
      if (ctrl.beginBurst) burstLeft <= firstBurst;
      if (ctrl.capture) dataBuf <= swapped;
      if (ctrl.stepElem) begin
        if (cmdWord[C_INC_SRC]) srcAddr <= srcAddr + WORD_W'(elemBytes);
        if (cmdWord[C_INC_TGT]) tgtAddr <= tgtAddr + WORD_W'(elemBytes);
        remain    <= remain - stepRemain;
        burstLeft <= burstLeft - stepBurst;
      end
    end
  end

  always_comb begin
    unique case (ctrl.addrSel)
      ADDR_SRC: memAddr = srcAddr;
      ADDR_TGT: memAddr = tgtAddr;
      default:  memAddr = descBase + {{(WORD_W-4){1'b0}}, wordIdx, 2'b00};
    endcase
  end

  assign memWdata  = dataBuf;
  assign lastWord  = (wordIdx == 2'd3);
  assign nextStop  = linkWord[0];
  assign lenZero   = (remain == '0);
  assign burstDone = (burstLeft == '0);
  assign paceSrc   = cmdWord[C_PACE_SRC];
  assign paceTgt   = cmdWord[C_PACE_TGT];
  assign irqBeg    = cmdWord[C_IRQ_BEG];
  assign irqFin    = cmdWord[C_IRQ_FIN];
endmodule

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl
  import dma_chain_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    srcReq,
  input  logic    tgtReq,
  input  logic    memAck,
  input  logic    memErr,
  input  logic    lastWord,
  input  logic    nextStop,
  input  logic    lenZero,
  input  logic    burstDone,
  input  logic    paceSrc,
  input  logic    paceTgt,
  input  logic    irqBeg,
  input  logic    irqFin,
  output dpCtrl_t ctrl,
  output logic    memReq,
  output logic    memWe,
  output logic    evStart,
  output logic    evEnd,
  output logic    busErr,
  output logic    stopped
);
  chanState_e state, nxt;
  logic paceOk;

  assign paceOk = (!paceSrc || srcReq) && (!paceTgt || tgtReq);

  always_comb begin
    nxt     = state;
    ctrl    = '0;
    memReq  = 1'b0;
    memWe   = 1'b0;
    evStart = 1'b0;
    evEnd   = 1'b0;
    unique case (state)
      S_IDLE: if (startReq) begin
        ctrl.loadFirst = 1'b1;
        nxt = S_FETCH;
      end
      S_FETCH: begin
        memReq = 1'b1;
        ctrl.addrSel = ADDR_DESC;
        if (memAck) begin
          if (memErr) nxt = S_IDLE;
          else begin
            ctrl.fetchWord = 1'b1;
            if (lastWord) nxt = S_LOADED;
          end
        end
      end
      S_LOADED: begin
        evStart = irqBeg;
        nxt = S_ARM;
      end
      S_ARM: begin
        if (lenZero) nxt = S_DONE;
        else if (paceOk) begin
          ctrl.beginBurst = 1'b1;
          nxt = S_RD;
        end
      end
      S_RD: begin
        memReq = 1'b1;
        ctrl.addrSel = ADDR_SRC;
        if (memAck) begin
          if (memErr) nxt = S_IDLE;
          else begin
            ctrl.capture = 1'b1;
            nxt = S_WR;
          end
        end
      end
      S_WR: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        ctrl.addrSel = ADDR_TGT;
        if (memAck) begin
          if (memErr) nxt = S_IDLE;
          else begin
            ctrl.stepElem = 1'b1;
            nxt = S_STEP;
          end
        end
      end
      S_STEP: begin
        if (lenZero) nxt = S_DONE;
        else if (burstDone) nxt = S_ARM;
        else nxt = S_RD;
      end
      S_DONE: begin
        evEnd = irqFin;
        if (nextStop) nxt = S_IDLE;
        else begin
          ctrl.loadNext = 1'b1;
          nxt = S_FETCH;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      busErr <= 1'b0;
    end else begin
      state <= nxt;
      if (state == S_IDLE && startReq) busErr <= 1'b0;
      else if (memReq && memAck && memErr) busErr <= 1'b1;
    end
  end

  assign stopped = (state == S_IDLE);
endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine
  import dma_chain_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [WORD_W-1:0] firstDesc,
  input  logic              srcReq,
  input  logic              tgtReq,
  output logic              memReq,
  output logic              memWe,
  output logic [WORD_W-1:0] memAddr,
  output logic [1:0]        memSize,
  output logic [WORD_W-1:0] memWdata,
  input  logic [WORD_W-1:0] memRdata,
  input  logic              memAck,
  input  logic              memErr,
  output logic              evStart,
  output logic              evEnd,
  output logic              busErr,
  output logic              stopped
);
  dpCtrl_t ctrl;
  logic lastWord, nextStop, lenZero, burstDone;
  logic paceSrc, paceTgt, irqBeg, irqFin;

  dma_chain_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .srcReq(srcReq),
    .tgtReq(tgtReq), .memAck(memAck), .memErr(memErr),
    .lastWord(lastWord), .nextStop(nextStop), .lenZero(lenZero),
    .burstDone(burstDone), .paceSrc(paceSrc), .paceTgt(paceTgt),
    .irqBeg(irqBeg), .irqFin(irqFin), .ctrl(ctrl), .memReq(memReq),
    .memWe(memWe), .evStart(evStart), .evEnd(evEnd), .busErr(busErr),
    .stopped(stopped)
  );

  dma_chain_datapath dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .firstDesc(firstDesc),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .memSize(memSize), .lastWord(lastWord), .nextStop(nextStop),
    .lenZero(lenZero), .burstDone(burstDone), .paceSrc(paceSrc),
    .paceTgt(paceTgt), .irqBeg(irqBeg), .irqFin(irqFin)
  );
endmodule

// File: rtl/dma_chain_engine_chk.sv
module dma_chain_engine_chk (
  input logic        clk,
  input logic        rstN,
  input logic        startReq,
  input logic        memReq,
  input logic        memWe,
  input logic [31:0] memAddr,
  input logic [1:0]  memSize,
  input logic        memAck,
  input logic        memErr,
  input logic        evStart,
  input logic        evEnd,
  input logic        busErr,
  input logic        stopped
);
  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe) && $stable(memSize));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopped |-> !memReq);

  // R2
  start_leaves_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    startReq && stopped |=> !stopped);

  // R8
  events_apart_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(evStart && evEnd));

  // R4
  size_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> memSize != 2'd3);

  // R9
  err_halts_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memAck && memErr |=> stopped && busErr && !memReq);

  // R9
  err_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busErr) |-> $past(memErr && memAck));
endmodule

bind dma_chain_engine dma_chain_engine_chk chk_i (
  .clk(clk), .rstN(rstN), .startReq(startReq), .memReq(memReq),
  .memWe(memWe), .memAddr(memAddr), .memSize(memSize), .memAck(memAck),
  .memErr(memErr), .evStart(evStart), .evEnd(evEnd), .busErr(busErr),
  .stopped(stopped)
);

// File: tb/dma_chain_engine_tb_top.sv
module dma_chain_engine_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [31:0] firstDesc = '0;
  logic srcReq = 1'b0, tgtReq = 1'b0;
  logic memReq, memWe;
  logic [31:0] memAddr, memWdata;
  logic [1:0] memSize;
  logic [31:0] memRdata = '0;
  logic memAck = 1'b0, memErr = 1'b0;
  logic evStart, evEnd, busErr, stopped;

  always #2.5 clk = ~clk;

  dma_chain_engine dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .firstDesc(firstDesc),
    .srcReq(srcReq), .tgtReq(tgtReq), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memSize(memSize), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck), .memErr(memErr),
    .evStart(evStart), .evEnd(evEnd), .busErr(busErr), .stopped(stopped)
  );

  int checks = 0, errors = 0;
  int wrCount = 0, begCount = 0, finCount = 0;
  logic [7:0] mem [0:4095];
  logic errEn = 1'b0;
  logic [31:0] errAddr = '0;

  typedef struct { logic [31:0] addr; logic [31:0] data; logic [1:0] size; } wrItem_t;
  wrItem_t expQ[$];

  function automatic logic [31:0] sizeMask(logic [1:0] s);
    return (s == 2'd0) ? 32'hFF : (s == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  // memory model: one acknowledge per request, one cycle after it is seen
  always @(posedge clk) begin
    if (memReq && !memAck) begin
      memAck <= 1'b1;
      memErr <= errEn && (memAddr == errAddr);
      if (!(errEn && (memAddr == errAddr))) begin
        if (memWe) begin
          for (int b = 0; b < 4; b++)
            if (b < (1 << memSize)) mem[(memAddr[11:0] + b) & 12'hFFF] <= memWdata[8*b +: 8];
        end else begin
          for (int b = 0; b < 4; b++)
            memRdata[8*b +: 8] <= mem[(memAddr[11:0] + b) & 12'hFFF];
        end
      end
    end else begin
      memAck <= 1'b0;
      memErr <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (evStart) begin_cnt_inc();
      if (evEnd) finCount++;
      if (memReq && memWe && memAck) begin
        wrCount++;
        if (expQ.size() == 0) begin
          checks++; errors++;
          $display("FAIL R2 unexpected write actual=%0h expected=none", memAddr);
        end else begin
          wrItem_t e;
          e = expQ.pop_front();
          check(memAddr == e.addr, "R3 write address", memAddr, e.addr);
          check(memSize == e.size, "R4 write size", {30'b0, memSize}, {30'b0, e.size});
          check((memWdata & sizeMask(e.size)) == e.data, "R5 write data",
                memWdata & sizeMask(e.size), e.data);
        end
      end
    end
  end

  function automatic void begin_cnt_inc();
    begCount++;
  endfunction

  function automatic logic [31:0] mkCmd(bit incS, bit incT, bit pS, bit pT, bit iB, bit iF,
                                        bit swp, logic [1:0] burst, logic [1:0] width, int len);
    logic [31:0] c = '0;
    c[31] = incS; c[30] = incT; c[29] = pS; c[28] = pT;
    c[22] = iB; c[21] = iF; c[18] = swp;
    c[17:16] = burst; c[15:14] = width; c[12:0] = len[12:0];
    return c;
  endfunction

  task automatic wr32(input logic [31:0] a, input logic [31:0] d);
    for (int b = 0; b < 4; b++) mem[(a[11:0] + b) & 12'hFFF] = d[8*b +: 8];
  endtask

  // driver: places a descriptor and pushes the writes it should produce
  task automatic addDesc(input logic [31:0] base, input logic [31:0] link, input logic [31:0] src,
                         input logic [31:0] tgt, input logic [31:0] cmd, input int maxElems);
    int w, n;
    logic [1:0] sz;
    wr32(base, link); wr32(base + 4, src); wr32(base + 8, tgt); wr32(base + 12, cmd);
    case (cmd[15:14]) 2'd1: begin w = 1; sz = 0; end
                      2'd2: begin w = 2; sz = 1; end
                      default: begin w = 4; sz = 2; end
    endcase
    n = int'(cmd[12:0]) / w;
    if (n > maxElems) n = maxElems;
    for (int k = 0; k < n; k++) begin
      wrItem_t it;
      logic [31:0] ra, d;
      ra = src + (cmd[31] ? k * w : 0);
      d = '0;
      for (int b = 0; b < w; b++)
        d[8*b +: 8] = mem[(ra[11:0] + b) & 12'hFFF];
      if (cmd[18] && w == 2) d = {16'b0, d[7:0], d[15:8]};
      if (cmd[18] && w == 4) d = {d[7:0], d[15:8], d[23:16], d[31:24]};
      it.addr = tgt + (cmd[30] ? k * w : 0);
      it.data = d;
      it.size = sz;
      expQ.push_back(it);
    end
  endtask

  task automatic kick(input logic [31:0] a);
    @(negedge clk); startReq = 1'b1; firstDesc = a;
    @(negedge clk); startReq = 1'b0;
  endtask

  task automatic waitIdle(input string tag);
    int n = 0;
    while (!stopped && n < 5000) begin @(negedge clk); n++; end
    check(stopped == 1'b1, tag, {31'b0, stopped}, 32'd1);
  endtask

  task automatic pulseSrc();
    @(negedge clk); srcReq = 1'b1;
    @(negedge clk); srcReq = 1'b0;
    repeat (80) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int w0, b0, f0;
    for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 7 + 3);
    repeat (4) @(negedge clk);
    // R1 reset state
    check(stopped == 1'b1, "R1 stopped after reset", {31'b0, stopped}, 32'd1);
    check(busErr == 1'b0, "R1 busErr after reset", {31'b0, busErr}, 32'd0);
    check(memReq == 1'b0, "R1 no request in reset", {31'b0, memReq}, 32'd0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(memReq == 1'b0 && begCount == 0 && finCount == 0, "R1 quiet after reset",
          {31'b0, memReq}, 32'd0);

    // single descriptor, word copy, misaligned start pointer (R2, R8)
    b0 = begCount; f0 = finCount;
    addDesc(32'h100, 32'h1, 32'h400, 32'h800, mkCmd(1, 1, 0, 0, 1, 1, 0, 2'd3, 2'd3, 16), 999);
    kick(32'h105);
    waitIdle("R2 single descriptor finishes");
    check(expQ.size() == 0, "R2 all writes seen", expQ.size(), 0);
    check(begCount - b0 == 1, "R8 start event", begCount - b0, 1);
    check(finCount - f0 == 1, "R8 end event", finCount - f0, 1);

    // chain: halfword swap, zero length, fixed byte target, stop flag (R3 R4 R5 R2)
    b0 = begCount; f0 = finCount;
    addDesc(32'h120, 32'h130, 32'h440, 32'h840, mkCmd(1, 1, 0, 0, 1, 0, 1, 2'd1, 2'd2, 6), 999);
    addDesc(32'h130, 32'h140, 32'h460, 32'h860, mkCmd(1, 1, 0, 0, 0, 1, 0, 2'd1, 2'd3, 0), 999);
    addDesc(32'h140, 32'h151, 32'h470, 32'h880, mkCmd(1, 0, 0, 0, 0, 1, 0, 2'd1, 2'd1, 5), 999);
    wr32(32'h150, 32'h1); wr32(32'h154, 32'h480); wr32(32'h158, 32'h8C0);
    wr32(32'h15C, mkCmd(1, 1, 0, 0, 0, 1, 0, 2'd1, 2'd3, 8));
    kick(32'h120);
    waitIdle("R2 chain finishes at stop flag");
    repeat (20) @(negedge clk);
    check(expQ.size() == 0, "R2 chain writes complete", expQ.size(), 0);
    check(begCount - b0 == 1, "R8 start event only where enabled", begCount - b0, 1);
    check(finCount - f0 == 2, "R4 zero-length descriptor still ends", finCount - f0, 2);

    // paced bursts, last burst cut short, start ignored while running (R6 R7 R10)
    w0 = wrCount; f0 = finCount;
    wr32(32'h170, 32'h1); wr32(32'h174, 32'h500); wr32(32'h178, 32'h900);
    wr32(32'h17C, mkCmd(1, 1, 0, 0, 0, 1, 0, 2'd3, 2'd3, 32));
    addDesc(32'h160, 32'h1, 32'h4A0, 32'h8A0, mkCmd(1, 1, 1, 0, 0, 1, 0, 2'd1, 2'd1, 20), 999);
    kick(32'h160);
    repeat (40) @(negedge clk);
    check(wrCount - w0 == 0, "R6 burst waits for source request", wrCount - w0, 0);
    kick(32'h170);
    check(stopped == 1'b0, "R10 still running after extra start", {31'b0, stopped}, 32'd0);
    pulseSrc();
    check(wrCount - w0 == 8, "R7 first burst of 8 bytes", wrCount - w0, 8);
    pulseSrc();
    check(wrCount - w0 == 16, "R7 second burst of 8 bytes", wrCount - w0, 16);
    pulseSrc();
    check(wrCount - w0 == 20, "R7 last burst shortened to 4", wrCount - w0, 20);
    check(stopped == 1'b1 && finCount - f0 == 1, "R10 extra start had no effect",
          {31'b0, stopped}, 32'd1);
    check(expQ.size() == 0, "R7 paced writes complete", expQ.size(), 0);

    // bus error on the third source read (R9)
    w0 = wrCount; f0 = finCount;
    addDesc(32'h180, 32'h1, 32'h600, 32'hA00, mkCmd(1, 1, 0, 0, 0, 1, 0, 2'd3, 2'd3, 16), 2);
    errAddr = 32'h608; errEn = 1'b1;
    kick(32'h180);
    waitIdle("R9 channel stops on error");
    repeat (10) @(negedge clk);
    check(busErr == 1'b1, "R9 busErr set", {31'b0, busErr}, 32'd1);
    check(wrCount - w0 == 2, "R9 no writes after error", wrCount - w0, 2);
    check(finCount - f0 == 0, "R9 no end event", finCount - f0, 0);
    errEn = 1'b0;

    // target pacing and busErr clearing (R6 R9)
    w0 = wrCount;
    srcReq = 1'b1;
    addDesc(32'h1A0, 32'h1, 32'h640, 32'hA40, mkCmd(1, 1, 0, 1, 0, 0, 0, 2'd2, 2'd3, 8), 999);
    kick(32'h1A0);
    check(busErr == 1'b0, "R9 busErr cleared by start", {31'b0, busErr}, 32'd0);
    repeat (30) @(negedge clk);
    check(wrCount - w0 == 0, "R6 burst waits for target request", wrCount - w0, 0);
    tgtReq = 1'b1;
    waitIdle("R6 target-paced run finishes");
    check(expQ.size() == 0 && wrCount - w0 == 2, "R6 target-paced writes", wrCount - w0, 2);
    srcReq = 1'b0; tgtReq = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule